// File: doc/BRIEF.md
# Execute Packet Dispatcher

This block sits between program memory and the issue stage of a wide-issue processor. Program memory delivers fetch packets, each a fixed row of instruction slots. The dispatcher reads a chain bit in each instruction word to find where each execute packet ends. It then presents each execute packet as a single issue group, with one instruction per lane. An execute packet is a set of instructions that all issue in the same cycle.

Instructions of an execute packet are placed in lanes 0, 1, 2 and upward, in program order. Two stream interfaces use valid/ready rules. On the fetch side, a fetch packet transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops while any slot of the held fetch packet is still undispatched. On the issue side, an execute packet transfers on a clock edge where `ep_valid` and `ep_ready` are both high. While `ep_ready` is low, the presented packet stays unchanged.

A chain that reaches the last slot of a fetch packet is held as a partial packet. The partial packet is completed from the front of the next fetch packet. Two checks are reported alongside each packet: whether two instructions name the same functional unit, and whether a chain ran past the lane count.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: After reset, `in_ready` is 1 and `ep_valid` is 0.
- R2: An instruction whose bit 0 is 0 ends its execute packet, and one whose bit 0 is 1 chains to the next slot. The instructions of a packet occupy lanes 0 up to n-1 in program order. `ep_lane_vld` has exactly those n low bits set, and `ep_words` carries lane k in bits [32k+31:32k].
- R3: While `ep_valid` is high and `ep_ready` is low, `ep_valid`, `ep_words` and `ep_lane_vld` hold their values into the next cycle.
- R4: A chain still open at slot 7 is kept and joined with the leading slots of the next fetch packet. No part of it is presented before the chain ends.
- R5: `ep_unit_clash` is 1 with a packet exactly when two of its instructions carry the same functional-unit field in bits [3:1].
- R6: When eight chained instructions all have bit 0 set, the packet is closed at eight lanes with `ep_too_long` set. The next slot then starts a new packet.
- R7: A synchronous reset drops any partial packet and any held fetch packet. The next fetch packet starts a new execute packet at its slot 0.
- R8: `ep_unit_clash` and `ep_too_long` are 0 whenever `ep_valid` is 0.
- R9: `in_ready` is 0 whenever an execute packet is presented, because its slots come from the held fetch packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetch packet available |
| in_ready | output | 1 | Dispatcher can take a fetch packet |
| in_data | input | 256 | Fetch packet, slot s in bits [32s+31:32s] |
| ep_valid | output | 1 | Execute packet presented |
| ep_ready | input | 1 | Issue stage takes the packet |
| ep_lane_vld | output | 8 | Occupied lanes of the packet |
| ep_words | output | 256 | Lane instruction words, lane k in bits [32k+31:32k] |
| ep_unit_clash | output | 1 | Two lanes name the same functional unit |
| ep_too_long | output | 1 | Chain exceeded eight instructions |

## Verification
If the slot read pointer went wrong, the next presented packet would show a skipped or repeated instruction, so the error is visible on the following handshake. If the partial-packet store were stale or not cleared, the first packet after a fetch boundary or after reset would carry extra leading lanes or miss some, visible within one or two cycles. The bench compares every presented packet, including its flags, with an independent model of the chain rule. It also watches that the presented packet stays unchanged under back-pressure and that the fetch side stays stalled while a packet is presented.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;
  localparam int DEF_LANES  = 8;
  localparam int DEF_IW     = 32;
  localparam int DEF_FU_LSB = 1;
  localparam int DEF_FU_W   = 3;

  // bit 0 of an instruction word chains it to the next slot
  function automatic logic chains(input logic [DEF_IW-1:0] w);
    return w[0];
  endfunction
endpackage

// File: rtl/ep_slicer.sv
module ep_slicer #(
  parameter int LANES = 8,
  parameter int IW    = 32,
  parameter int PTR_W = $clog2(LANES),
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0][IW-1:0]  fp_words,
  input  logic [PTR_W-1:0]          rd_ptr,
  input  logic [LANES-1:0][IW-1:0]  acc_words,
  input  logic [CNT_W-1:0]          acc_cnt,
  output logic [LANES-1:0][IW-1:0]  lane_words,
  output logic [LANES-1:0]          lane_vld,
  output logic                      done,
  output logic                      too_long,
  output logic [PTR_W-1:0]          last_slot,
  output logic [CNT_W-1:0]          cnt_out
);
  always_comb begin
    int   ln;
    logic stop;
    lane_words = '0;
    lane_vld   = '0;
    done       = 1'b0;
    too_long   = 1'b0;
    last_slot  = '0;
    stop       = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (l < int'(acc_cnt)) begin
        lane_words[l] = acc_words[l];
        lane_vld[l]   = 1'b1;
      end
    end
    ln = int'(acc_cnt);
    for (int s = 0; s < LANES; s++) begin
      if (s >= int'(rd_ptr) && !stop && ln < LANES) begin
        lane_words[ln[PTR_W-1:0]] = fp_words[s];
        lane_vld[ln[PTR_W-1:0]]   = 1'b1;
        last_slot = PTR_W'(s);
        if (!fp_words[s][0]) begin
          stop = 1'b1;
          done = 1'b1;
        end else if (ln == LANES - 1) begin
          stop     = 1'b1;
          done     = 1'b1;
          too_long = 1'b1;
        end
        ln = ln + 1;
      end
    end
    cnt_out = CNT_W'(ln);
  end

  // R2: occupied lanes form a contiguous run from lane 0
  p_contig_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (lane_vld[0] && ((lane_vld & (lane_vld + 1'b1)) == '0)));
  // R6: a too-long close fills every lane
  p_full_r6: assert property (@(posedge clk) disable iff (rst)
    too_long |-> (&lane_vld));
endmodule

// File: rtl/ep_unit_check.sv
module ep_unit_check #(
  parameter int LANES  = 8,
  parameter int IW     = 32,
  parameter int FU_LSB = 1,
  parameter int FU_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0][IW-1:0] lane_words,
  input  logic [LANES-1:0]         lane_vld,
  output logic                     clash
);
  logic [LANES-1:0][FU_W-1:0] unit_id;

  for (genvar g = 0; g < LANES; g++) begin : g_unit
    assign unit_id[g] = lane_words[g][FU_LSB +: FU_W];
  end

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < LANES; j++) begin
        if (j > i && lane_vld[i] && lane_vld[j] && unit_id[i] == unit_id[j])
          clash = 1'b1;
      end
    end
  end

  // R5: a packet of at most one instruction can never clash
  p_single_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_vld) |-> !clash);
endmodule

// File: rtl/vliw_ep_dispatch.sv
module vliw_ep_dispatch #(
  parameter int LANES  = vliw_disp_pkg::DEF_LANES,
  parameter int IW     = vliw_disp_pkg::DEF_IW,
  parameter int FU_LSB = vliw_disp_pkg::DEF_FU_LSB,
  parameter int FU_W   = vliw_disp_pkg::DEF_FU_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*IW-1:0]   in_data,
  output logic                  ep_valid,
  input  logic                  ep_ready,
  output logic [LANES-1:0]      ep_lane_vld,
  output logic [LANES*IW-1:0]   ep_words,
  output logic                  ep_unit_clash,
  output logic                  ep_too_long
);
  localparam int PTR_W = $clog2(LANES);
  localparam int CNT_W = $clog2(LANES + 1);

  logic [LANES-1:0][IW-1:0] fp_buf, acc_w, lanes;
  logic                     fp_full;
  logic [PTR_W-1:0]         rd_ptr, last_slot;
  logic [CNT_W-1:0]         acc_cnt, cnt_out;
  logic [LANES-1:0]         vld;
  logic                     done, too_long, clash;

  ep_slicer #(.LANES(LANES), .IW(IW), .PTR_W(PTR_W), .CNT_W(CNT_W)) slicer_i (
    .clk(clk), .rst(rst), .fp_words(fp_buf), .rd_ptr(rd_ptr),
    .acc_words(acc_w), .acc_cnt(acc_cnt), .lane_words(lanes), .lane_vld(vld),
    .done(done), .too_long(too_long), .last_slot(last_slot), .cnt_out(cnt_out)
  );

  ep_unit_check #(.LANES(LANES), .IW(IW), .FU_LSB(FU_LSB), .FU_W(FU_W)) ucheck_i (
    .clk(clk), .rst(rst), .lane_words(lanes), .lane_vld(vld), .clash(clash)
  );

  assign in_ready      = !fp_full;
  assign ep_valid      = fp_full && done;
  assign ep_lane_vld   = ep_valid ? vld : '0;
  assign ep_words      = ep_valid ? lanes : '0;
  assign ep_unit_clash = ep_valid && clash;
  assign ep_too_long   = ep_valid && too_long;

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_full <= 1'b0;
      fp_buf  <= '0;
      rd_ptr  <= '0;
      acc_w   <= '0;
      acc_cnt <= '0;
    end else if (in_valid && in_ready) begin
      fp_buf  <= in_data;
      fp_full <= 1'b1;
      rd_ptr  <= '0;
    end else if (fp_full) begin
      if (done) begin
        if (ep_ready) begin
          acc_w   <= '0;
          acc_cnt <= '0;
          if (last_slot == PTR_W'(LANES - 1)) fp_full <= 1'b0;
          else                                rd_ptr  <= last_slot + 1'b1;
        end
      end else begin
        // chain open at the last slot: keep the fragment, release the row
        acc_w   <= lanes;
        acc_cnt <= cnt_out;
        fp_full <= 1'b0;
      end
    end
  end

  // R3: a presented packet holds under back-pressure
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ep_valid && !ep_ready) |=> (ep_valid && $stable(ep_words) && $stable(ep_lane_vld)));
  // R9: fetch side stalls while a packet is presented
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> !in_ready);
  // R8: flags quiet without a packet
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !ep_valid |-> (!ep_unit_clash && !ep_too_long));
  // R7: reset leaves nothing presented and the fetch side open
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (!ep_valid && in_ready));
endmodule

// File: tb/vliw_ep_dispatch_tb.sv
module vliw_ep_dispatch_tb_top;
  localparam int PERIOD = 10;
  localparam int LANES  = 8;
  localparam int IW     = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*IW-1:0] in_data = '0;
  logic ep_valid;
  logic ep_ready = 1'b0;
  logic [LANES-1:0] ep_lane_vld;
  logic [LANES*IW-1:0] ep_words;
  logic ep_unit_clash, ep_too_long;

  int total = 0;
  int bad = 0;
  int rdy_pct = 100;
  bit took;

  logic [LANES*IW-1:0] q_words[$];
  logic [LANES-1:0]    q_vld[$];
  bit                  q_clash[$];
  bit                  q_long[$];
  logic [IW-1:0]       m_w[LANES];
  int                  m_n = 0;

  bit                  hold_pend = 0;
  logic [LANES*IW-1:0] hold_words;
  logic [LANES-1:0]    hold_vld;

  always #(PERIOD/2) clk = ~clk;

  vliw_ep_dispatch dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ep_valid(ep_valid), .ep_ready(ep_ready),
    .ep_lane_vld(ep_lane_vld), .ep_words(ep_words),
    .ep_unit_clash(ep_unit_clash), .ep_too_long(ep_too_long)
  );

  task automatic chk(input bit ok, input string req, input logic [LANES*IW-1:0] act,
                     input logic [LANES*IW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk(input int unit, input bit p, input int tag);
    logic [IW-1:0] w;
    w = IW'(tag) << 4;
    w[3:1] = 3'(unit);
    w[0] = p;
    return w;
  endfunction

  task automatic model_slot(input logic [IW-1:0] w);
    logic [LANES*IW-1:0] v;
    logic [LANES-1:0]    m;
    bit                  c;
    m_w[m_n] = w;
    m_n++;
    if (!w[0] || m_n == LANES) begin
      v = '0; m = '0; c = 0;
      for (int k = 0; k < m_n; k++) begin
        v[k*IW +: IW] = m_w[k];
        m[k] = 1'b1;
        for (int j = k + 1; j < m_n; j++)
          if (m_w[k][3:1] == m_w[j][3:1]) c = 1;
      end
      q_words.push_back(v);
      q_vld.push_back(m);
      q_clash.push_back(c);
      q_long.push_back(w[0]);
      m_n = 0;
    end
  endtask

  // one clock: drive at the falling edge, predict the coming rising edge
  task automatic cycle(input bit iv, input logic [LANES*IW-1:0] d);
    @(negedge clk);
    in_valid = iv;
    in_data  = d;
    ep_ready = ($urandom % 100) < rdy_pct;
    #1;
    took = 0;
    if (rst) return;
    if (hold_pend) begin
      chk(ep_valid && ep_words == hold_words && ep_lane_vld == hold_vld, "R3",
          ep_words, hold_words);
      hold_pend = 0;
    end
    chk(!(ep_valid && in_ready), "R9", {255'(0), in_ready}, '0);
    chk(ep_valid || (!ep_unit_clash && !ep_too_long), "R8",
        {254'(0), ep_unit_clash, ep_too_long}, '0);
    if (ep_valid && !ep_ready) begin
      hold_pend  = 1;
      hold_words = ep_words;
      hold_vld   = ep_lane_vld;
    end
    if (ep_valid && ep_ready) begin
      if (q_words.size() == 0) begin
        chk(0, "R4 unexpected packet", ep_words, '0);
      end else begin
        chk(ep_words == q_words[0], "R2 R4 words", ep_words, q_words[0]);
        chk(ep_lane_vld == q_vld[0], "R2 lanes", {248'(0), ep_lane_vld}, {248'(0), q_vld[0]});
        chk(ep_unit_clash == q_clash[0], "R5 clash", {255'(0), ep_unit_clash}, {255'(0), q_clash[0]});
        chk(ep_too_long == q_long[0], "R6 long", {255'(0), ep_too_long}, {255'(0), q_long[0]});
        void'(q_words.pop_front()); void'(q_vld.pop_front());
        void'(q_clash.pop_front()); void'(q_long.pop_front());
      end
    end
    if (iv && in_ready) begin
      took = 1;
      for (int s = 0; s < LANES; s++) model_slot(d[s*IW +: IW]);
    end
  endtask

  task automatic send_fp(input logic [LANES*IW-1:0] d);
    took = 0;
    while (!took) cycle(1'b1, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, '0);
  endtask

  task automatic drain();
    int save = rdy_pct;
    rdy_pct = 100;
    idle(20);
    chk(q_words.size() == 0, "R2 drained", 256'(q_words.size()), '0);
    rdy_pct = save;
  endtask

  function automatic logic [LANES*IW-1:0] rand_fp(input int p_pct);
    logic [LANES*IW-1:0] d;
    for (int s = 0; s < LANES; s++)
      d[s*IW +: IW] = mk($urandom % 8, ($urandom % 100) < p_pct, $urandom);
    return d;
  endfunction

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [LANES*IW-1:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(in_ready && !ep_valid, "R1", {254'(0), in_ready, ep_valid}, {254'(0), 2'b10});

    // single-instruction packets, distinct units
    for (int s = 0; s < LANES; s++) d[s*IW +: IW] = mk(s, 0, 100 + s);
    send_fp(d); drain();

    // R4 spanning packet: slots 5..7 chain into the next row
    for (int s = 0; s < 5; s++) d[s*IW +: IW] = mk(s, 0, 200 + s);
    for (int s = 5; s < 8; s++) d[s*IW +: IW] = mk(s - 5, 1, 200 + s);
    send_fp(d);
    d[0 +: IW] = mk(3, 1, 300);
    d[IW +: IW] = mk(4, 0, 301);
    for (int s = 2; s < 8; s++) d[s*IW +: IW] = mk(s, 0, 300 + s);
    send_fp(d); drain();

    // R6 eight chained, then leftover chain of two
    for (int s = 0; s < LANES; s++) d[s*IW +: IW] = mk(s, 1, 400 + s);
    send_fp(d);
    d[0 +: IW] = mk(1, 1, 500);
    d[IW +: IW] = mk(2, 0, 501);
    for (int s = 2; s < 8; s++) d[s*IW +: IW] = mk(s, 0, 500 + s);
    send_fp(d); drain();

    // R5 clash on shared unit 5, under back-pressure for R3
    rdy_pct = 30;
    for (int s = 0; s < LANES; s++) d[s*IW +: IW] = mk(s, 0, 600 + s);
    d[0 +: IW] = mk(5, 1, 600);
    d[IW +: IW] = mk(5, 0, 601);
    send_fp(d); drain();
    rdy_pct = 100;

    // R7 reset drops a held partial packet
    for (int s = 0; s < LANES; s++) d[s*IW +: IW] = mk(s, s == 7, 700 + s);
    send_fp(d); drain();
    @(negedge clk); rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_n = 0;
    #1;
    chk(in_ready && !ep_valid, "R7 after reset", {254'(0), in_ready, ep_valid}, {254'(0), 2'b10});
    for (int s = 0; s < LANES; s++) d[s*IW +: IW] = mk(s, 0, 800 + s);
    send_fp(d);
    idle(1);
    chk(ep_valid && ep_lane_vld == 8'h01 && ep_words[IW-1:0] == mk(0, 0, 800),
        "R7 fresh start", ep_words, {224'(0), mk(0, 0, 800)});
    drain();

    // random traffic
    rdy_pct = 70;
    for (int n = 0; n < 400; n++) begin
      idle($urandom % 3);
      send_fp(rand_fp((n % 4 == 0) ? 90 : 60));
    end
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule